// File: doc/BRIEF.md
# CPU Power-Domain Bring-Up Sequencer

This block brings a secondary CPU out of power-down and lets it run. A single-cycle start pulse carries a CPU index. The sequencer first checks whether that CPU's reset-release bit is already set. If it is, the sequence ends at once with success and no output changes.

Otherwise the sequencer powers the CPU in two stages, logic first and then local RAM:
- **Logic stage.** It raises a two-bit power-on switch pair and waits for both acknowledges. It then raises a two-bit power-good pair, still holding power-on, and waits for both of those acknowledges. After that it drops the logic isolation clamp.
- **Memory stage.** It clears the memory array power-down field. It then raises memory power-on and waits for its acknowledge, raises memory power-good and waits again, and finally drops the memory clamp.

Only after both stages does it set the CPU's active-low reset release bit. That bit is held per CPU alongside the power outputs.

Every acknowledge wait is bounded by a programmable cycle limit. If the limit runs out, the block aborts with an error pulse. It leaves all outputs where they stood and never releases reset.

Top module: `cpu_pwrup_seq`

## Requirements
- R1: After synchronous reset, for both CPUs:
  - all power-on, power-good, memory power-on and memory power-good outputs are 0;
  - both clamps are 1;
  - the 4-bit memory power-down field is all ones;
  - the reset-release bits are 0;
  - busy, done and error are 0.
- R2: A request for a CPU whose reset-release bit is already 1 raises done two cycles after the start pulse and changes no power, clamp, memory or release output.
- R3: The power-on pair of the target CPU (bits 2i+1:2i of the pair outputs) is set in the cycle after the check. Power-good is not raised until both power-on acknowledge bits of that CPU are 1.
- R4: Power-good (both bits) is raised while power-on stays set. The logic clamp is not dropped until both power-good acknowledge bits are 1.
- R5: The logic clamp clears, then the memory power-down field clears to 0 one cycle later, then memory power-on rises one cycle after that.
- R6: Memory power-good rises only after the memory power-on acknowledge. The memory clamp clears only after the memory power-good acknowledge.
- R7: Reset release for the target CPU is set one cycle after the memory clamp clears, as the final action. The other CPU's outputs and release bit are unchanged throughout.
- R8: A start pulse while busy is ignored: it neither restarts the sequence nor changes the target CPU.
- R9: If an acknowledge is still missing after limit+1 wait cycles, error pulses for one cycle, all outputs hold their values, the release bit stays 0, and the block returns to idle.
- R10: Done and error are single-cycle pulses and never coincide. Busy is 1 from the cycle after an accepted start through the cycle of done or error, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle bring-up request |
| cpu_i | input | 1 | Index of the CPU to bring up |
| tmo_lim_i | input | 16 | Acknowledge wait limit in cycles |
| pon_ack_i | input | 4 | Power-on status pairs, two bits per CPU |
| pok_ack_i | input | 4 | Power-good status pairs, two bits per CPU |
| mon_ack_i | input | 2 | Memory power-on status, one per CPU |
| mok_ack_i | input | 2 | Memory power-good status, one per CPU |
| pon_o | output | 4 | Power-on switch pairs |
| pok_o | output | 4 | Power-good switch pairs |
| lclamp_o | output | 2 | Logic isolation clamps, 1 = clamped |
| pda_o | output | 8 | Memory array power-down fields, 4 bits per CPU |
| mon_o | output | 2 | Memory power-on |
| mok_o | output | 2 | Memory power-good |
| mclamp_o | output | 2 | Memory clamps, 1 = clamped |
| rel_o | output | 2 | Active-low reset release, 1 = CPU running |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Timeout pulse |

## Verification
The assertions watch, on every cycle, the invariants that hold regardless of scenario:
- power-good never stands without both power-on bits;
- memory power-good never stands without memory power-on and a cleared power-down field;
- a release bit rises only with the memory clamp off;
- an error leaves the release bits untouched;
- done and error never coincide and are followed by idle;
- the latched target stays fixed while busy.

Exact step ordering and cycle placement need the bench scenarios. So do the already-on shortcut, the ignored mid-sequence request, and the timeout boundary at one limit value either side of the acknowledge latency. The bench observes these through its cycle-by-cycle reference model.

// File: rtl/cpu_pwrup_pkg.sv
package cpu_pwrup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHK,
        ST_W_PON,
        ST_W_POK,
        ST_LCLR,
        ST_PDA,
        ST_W_MON,
        ST_W_MOK,
        ST_REL,
        ST_FIN,
        ST_ERR
    } seq_state_e;

    // One-hot-ish action strobes issued to a power domain bank
    typedef struct packed {
        logic set_pon;
        logic set_pok;
        logic clr_lclamp;
        logic clr_pda;
        logic set_mon;
        logic set_mok;
        logic clr_mclamp;
        logic set_rel;
    } dom_cmd_t;

    localparam dom_cmd_t CMD_NONE = '0;

    function automatic logic is_wait(seq_state_e s);
        return (s == ST_W_PON) || (s == ST_W_POK) ||
               (s == ST_W_MON) || (s == ST_W_MOK);
    endfunction

endpackage

// File: rtl/cpu_pwrup_tmr.sv
module cpu_pwrup_tmr #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [TW-1:0] lim,
    output logic          expired
);
    logic [TW-1:0] cnt;

    assign expired = (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cpu_pwrup_dom.sv
module cpu_pwrup_dom
    import cpu_pwrup_pkg::*;
#(
    parameter int PDAW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel,
    input  dom_cmd_t        cmd,
    output logic [1:0]      pon_o,
    output logic [1:0]      pok_o,
    output logic            lclamp_o,
    output logic [PDAW-1:0] pda_o,
    output logic            mon_o,
    output logic            mok_o,
    output logic            mclamp_o,
    output logic            rel_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pon_o    <= '0;
            pok_o    <= '0;
            lclamp_o <= 1'b1;
            pda_o    <= '1;
            mon_o    <= 1'b0;
            mok_o    <= 1'b0;
            mclamp_o <= 1'b1;
            rel_o    <= 1'b0;
        end else if (sel) begin
            if (cmd.set_pon)    pon_o    <= '1;
            if (cmd.set_pok)    pok_o    <= '1;
            if (cmd.clr_lclamp) lclamp_o <= 1'b0;
            if (cmd.clr_pda)    pda_o    <= '0;
            if (cmd.set_mon)    mon_o    <= 1'b1;
            if (cmd.set_mok)    mok_o    <= 1'b1;
            if (cmd.clr_mclamp) mclamp_o <= 1'b0;
            if (cmd.set_rel)    rel_o    <= 1'b1;
        end
    end

    // R3: power-good pair never stands without the full power-on pair
    a_r3_pok_needs_pon: assert property (@(posedge clk) disable iff (rst)
        (|pok_o) |-> (&pon_o));

    // R6: memory power-good implies memory power-on and a cleared array field
    a_r6_mok_needs_mon: assert property (@(posedge clk) disable iff (rst)
        mok_o |-> (mon_o && (pda_o == '0)));

    // R7: release appears only once the memory clamp is gone
    a_r7_rel_after_clamp: assert property (@(posedge clk) disable iff (rst)
        $rose(rel_o) |-> (!mclamp_o && mok_o && !lclamp_o));
endmodule

// File: rtl/cpu_pwrup_seq.sv
module cpu_pwrup_seq
    import cpu_pwrup_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int TW   = 16,
    parameter int PDAW = 4,
    localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [CW-1:0]      cpu_i,
    input  logic [TW-1:0]      tmo_lim_i,
    input  logic [2*NCPU-1:0]  pon_ack_i,
    input  logic [2*NCPU-1:0]  pok_ack_i,
    input  logic [NCPU-1:0]    mon_ack_i,
    input  logic [NCPU-1:0]    mok_ack_i,
    output logic [2*NCPU-1:0]  pon_o,
    output logic [2*NCPU-1:0]  pok_o,
    output logic [NCPU-1:0]    lclamp_o,
    output logic [PDAW*NCPU-1:0] pda_o,
    output logic [NCPU-1:0]    mon_o,
    output logic [NCPU-1:0]    mok_o,
    output logic [NCPU-1:0]    mclamp_o,
    output logic [NCPU-1:0]    rel_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    seq_state_e state, state_nx;
    logic [CW-1:0] cpu_q;
    logic          ack_sel, rel_sel, tmo_exp, tmo_clr;
    dom_cmd_t      cmd;

    assign rel_sel = rel_o[cpu_q];
    assign busy_o  = (state != ST_IDLE);
    assign done_o  = (state == ST_FIN);
    assign err_o   = (state == ST_ERR);

    always_comb begin
        unique case (state)
            ST_W_PON: ack_sel = &pon_ack_i[2*int'(cpu_q) +: 2];
            ST_W_POK: ack_sel = &pok_ack_i[2*int'(cpu_q) +: 2];
            ST_W_MON: ack_sel = mon_ack_i[cpu_q];
            ST_W_MOK: ack_sel = mok_ack_i[cpu_q];
            default:  ack_sel = 1'b0;
        endcase
    end

    assign tmo_clr = !is_wait(state) || ack_sel;

    cpu_pwrup_tmr #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmo_clr),
        .lim     (tmo_lim_i),
        .expired (tmo_exp)
    );

    always_comb begin
        state_nx = state;
        cmd      = CMD_NONE;
        unique case (state)
            ST_IDLE: if (start_i) state_nx = ST_CHK;
            ST_CHK: begin
                if (rel_sel) begin
                    state_nx = ST_FIN;
                end else begin
                    cmd.set_pon = 1'b1;
                    state_nx    = ST_W_PON;
                end
            end
            ST_W_PON: begin
                if (ack_sel) begin
                    cmd.set_pok = 1'b1;
                    state_nx    = ST_W_POK;
                end else if (tmo_exp) begin
                    state_nx = ST_ERR;
                end
            end
            ST_W_POK: begin
                if (ack_sel) begin
                    cmd.clr_lclamp = 1'b1;
                    state_nx       = ST_LCLR;
                end else if (tmo_exp) begin
                    state_nx = ST_ERR;
                end
            end
            ST_LCLR: begin
                cmd.clr_pda = 1'b1;
                state_nx    = ST_PDA;
            end
            ST_PDA: begin
                cmd.set_mon = 1'b1;
                state_nx    = ST_W_MON;
            end
            ST_W_MON: begin
                if (ack_sel) begin
                    cmd.set_mok = 1'b1;
                    state_nx    = ST_W_MOK;
                end else if (tmo_exp) begin
                    state_nx = ST_ERR;
                end
            end
            ST_W_MOK: begin
                if (ack_sel) begin
                    cmd.clr_mclamp = 1'b1;
                    state_nx       = ST_REL;
                end else if (tmo_exp) begin
                    state_nx = ST_ERR;
                end
            end
            ST_REL: begin
                cmd.set_rel = 1'b1;
                state_nx    = ST_FIN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cpu_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start_i) cpu_q <= cpu_i;
        end
    end

    for (genvar g = 0; g < NCPU; g++) begin : g_dom
        cpu_pwrup_dom #(.PDAW(PDAW)) u_dom (
            .clk      (clk),
            .rst      (rst),
            .sel      (cpu_q == CW'(g)),
            .cmd      (cmd),
            .pon_o    (pon_o[2*g +: 2]),
            .pok_o    (pok_o[2*g +: 2]),
            .lclamp_o (lclamp_o[g]),
            .pda_o    (pda_o[PDAW*g +: PDAW]),
            .mon_o    (mon_o[g]),
            .mok_o    (mok_o[g]),
            .mclamp_o (mclamp_o[g]),
            .rel_o    (rel_o[g])
        );
    end

    // R10: done and error are exclusive and are followed by idle
    a_r10_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));
    a_r10_back_idle: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o) |=> !busy_o);

    // R9: an abort never touches the release bits
    a_r9_err_keeps_rel: assert property (@(posedge clk) disable iff (rst)
        err_o |=> $stable(rel_o));

    // R8: the latched target holds while a sequence runs
    a_r8_target_held: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(cpu_q));
endmodule

// File: tb/cpu_pwrup_seq_bench.sv
module cpu_pwrup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 2;
    localparam int TW   = 16;
    localparam int PDAW = 4;
    localparam int DLY  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [0:0] cpu = '0;
    logic [TW-1:0] lim = 16'd10;
    logic [2*N-1:0] pon_ack, pok_ack, pon_o, pok_o;
    logic [N-1:0] mon_ack, mok_ack, lclamp_o, mon_o, mok_o, mclamp_o, rel_o;
    logic [PDAW*N-1:0] pda_o;
    logic busy_o, done_o, err_o;

    // Acknowledge suppression masks for timeout scenarios
    logic [2*N-1:0] kill_pon = '0, kill_pok = '0;
    logic [N-1:0]   kill_mon = '0, kill_mok = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_pwrup_seq u_cpu_pwrup_seq (
        .clk(clk), .rst(rst), .start_i(start), .cpu_i(cpu), .tmo_lim_i(lim),
        .pon_ack_i(pon_ack), .pok_ack_i(pok_ack), .mon_ack_i(mon_ack), .mok_ack_i(mok_ack),
        .pon_o(pon_o), .pok_o(pok_o), .lclamp_o(lclamp_o), .pda_o(pda_o),
        .mon_o(mon_o), .mok_o(mok_o), .mclamp_o(mclamp_o), .rel_o(rel_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    // Switch model: status follows request after DLY half-shifted stages
    logic [2*N-1:0] pon_p [DLY];
    logic [2*N-1:0] pok_p [DLY];
    logic [N-1:0]   mon_p [DLY];
    logic [N-1:0]   mok_p [DLY];
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < DLY; i++) begin
                pon_p[i] <= '0; pok_p[i] <= '0; mon_p[i] <= '0; mok_p[i] <= '0;
            end
        end else begin
            pon_p[0] <= pon_o & ~kill_pon;
            pok_p[0] <= pok_o & ~kill_pok;
            mon_p[0] <= mon_o & ~kill_mon;
            mok_p[0] <= mok_o & ~kill_mok;
            for (int i = 1; i < DLY; i++) begin
                pon_p[i] <= pon_p[i-1]; pok_p[i] <= pok_p[i-1];
                mon_p[i] <= mon_p[i-1]; mok_p[i] <= mok_p[i-1];
            end
        end
    end
    assign pon_ack = pon_p[DLY-1];
    assign pok_ack = pok_p[DLY-1];
    assign mon_ack = mon_p[DLY-1];
    assign mok_ack = mok_p[DLY-1];

    // Behavioural reference: a step number and per-CPU integer state
    int m_step, m_cpu, m_wait;
    int m_pon[N], m_pok[N], m_lcl[N], m_pda[N], m_mon[N], m_mok[N], m_mcl[N], m_rel[N];

    function automatic bit m_ack(int step, int c);
        case (step)
            2: return pon_ack[2*c] && pon_ack[2*c+1];
            3: return pok_ack[2*c] && pok_ack[2*c+1];
            6: return mon_ack[c];
            7: return mok_ack[c];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_step = 0; m_cpu = 0; m_wait = 0;
            for (int c = 0; c < N; c++) begin
                m_pon[c] = 0; m_pok[c] = 0; m_lcl[c] = 1; m_pda[c] = 15;
                m_mon[c] = 0; m_mok[c] = 0; m_mcl[c] = 1; m_rel[c] = 0;
            end
        end else begin
            case (m_step)
                0: if (start) begin m_cpu = int'(cpu); m_step = 1; end
                1: if (m_rel[m_cpu] != 0) m_step = 20;
                   else begin m_pon[m_cpu] = 3; m_step = 2; m_wait = 0; end
                2, 3, 6, 7: begin
                    if (m_ack(m_step, m_cpu)) begin
                        if (m_step == 2) m_pok[m_cpu] = 3;
                        if (m_step == 3) m_lcl[m_cpu] = 0;
                        if (m_step == 6) m_mok[m_cpu] = 1;
                        if (m_step == 7) m_mcl[m_cpu] = 0;
                        m_step = m_step + 1; m_wait = 0;
                    end else if (m_wait == int'(lim)) m_step = 21;
                    else m_wait++;
                end
                4: begin m_pda[m_cpu] = 0; m_step = 5; end
                5: begin m_mon[m_cpu] = 1; m_step = 6; m_wait = 0; end
                8: begin m_rel[m_cpu] = 1; m_step = 20; end
                default: m_step = 0;
            endcase
        end
    end

    int n_chk = 0, n_fail = 0, n_done = 0, n_err = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        logic [2*N-1:0] e_pon, e_pok;
        logic [N-1:0] e_lcl, e_mon, e_mok, e_mcl, e_rel;
        logic [PDAW*N-1:0] e_pda;
        cyc++;
        if (!rst && !finished) begin
            for (int c = 0; c < N; c++) begin
                e_pon[2*c +: 2] = 2'(m_pon[c]); e_pok[2*c +: 2] = 2'(m_pok[c]);
                e_lcl[c] = m_lcl[c][0]; e_pda[PDAW*c +: PDAW] = PDAW'(m_pda[c]);
                e_mon[c] = m_mon[c][0]; e_mok[c] = m_mok[c][0];
                e_mcl[c] = m_mcl[c][0]; e_rel[c] = m_rel[c][0];
            end
            chk(pon_o == e_pon, "R3 power-on pair", int'(pon_o), int'(e_pon));
            chk(pok_o == e_pok, "R4 power-good pair", int'(pok_o), int'(e_pok));
            chk(lclamp_o == e_lcl, "R5 logic clamp", int'(lclamp_o), int'(e_lcl));
            chk(pda_o == e_pda, "R5 array power-down", int'(pda_o), int'(e_pda));
            chk({mon_o, mok_o, mclamp_o} == {e_mon, e_mok, e_mcl}, "R6 memory controls",
                int'({mon_o, mok_o, mclamp_o}), int'({e_mon, e_mok, e_mcl}));
            chk(rel_o == e_rel, "R7 release bits", int'(rel_o), int'(e_rel));
            chk({busy_o, done_o, err_o} == {m_step != 0, m_step == 20, m_step == 21},
                "R10 busy/done/err", int'({busy_o, done_o, err_o}),
                int'({m_step != 0, m_step == 20, m_step == 21}));
            if (done_o) n_done++;
            if (err_o) n_err++;
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic pulse_start(int c);
        @(negedge clk); start = 1'b1; cpu = 1'(c);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        kill_pon = '0; kill_pok = '0; kill_mon = '0; kill_mok = '0;
        repeat (2) @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        logic [31:0] snap;
        int d0, e0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({pon_o, pok_o, mon_o, mok_o, rel_o} == '0, "R1 reset levels zero",
            int'({pon_o, pok_o, mon_o, mok_o, rel_o}), 0);
        chk({lclamp_o, mclamp_o} == 4'hF && pda_o == 8'hFF, "R1 reset clamps/array",
            int'({lclamp_o, mclamp_o, pda_o}), 'hFFF);
        chk({busy_o, done_o, err_o} == 3'b000, "R1 reset status", int'({busy_o, done_o, err_o}), 0);
        rst = 1'b0;

        // Normal bring-up of CPU0 (R3..R7)
        d0 = n_done;
        pulse_start(0);
        wait_end();
        chk(n_done == d0 + 1, "R10 one done pulse", n_done - d0, 1);
        chk(rel_o == 2'b01, "R7 only CPU0 released", int'(rel_o), 1);
        chk(pon_o[3:2] == 2'b00 && lclamp_o[1], "R7 CPU1 untouched", int'({pon_o[3:2], lclamp_o[1]}), 1);

        // Already-on shortcut (R2)
        snap = {pon_o, pok_o, lclamp_o, pda_o, mon_o, mok_o, mclamp_o, rel_o};
        @(negedge clk); start = 1'b1; cpu = 1'b0;
        @(negedge clk); start = 1'b0;
        chk(busy_o && !done_o, "R2 check cycle", int'({busy_o, done_o}), 2);
        @(negedge clk);
        chk(done_o == 1'b1, "R2 done two cycles after start", int'(done_o), 1);
        chk({pon_o, pok_o, lclamp_o, pda_o, mon_o, mok_o, mclamp_o, rel_o} == snap,
            "R2 outputs unchanged", int'({pon_o, pok_o, lclamp_o, pda_o, mon_o, mok_o, mclamp_o, rel_o}), int'(snap));
        @(negedge clk);

        // Timeout on CPU1 power-good (R9)
        lim = 16'd4; kill_pok = 4'b1000; e0 = n_err;
        pulse_start(1);
        wait_end();
        chk(n_err == e0 + 1, "R9 error pulse", n_err - e0, 1);
        chk(rel_o[1] == 1'b0 && pok_o[3:2] == 2'b11 && lclamp_o[1], "R9 outputs held, no release",
            int'({rel_o[1], pok_o[3:2], lclamp_o[1]}), 'b0111);

        // Restart CPU1 with a mid-sequence request for CPU0 (R8)
        kill_pok = '0; lim = 16'd10; d0 = n_done;
        pulse_start(1);
        repeat (3) @(negedge clk);
        @(negedge clk); start = 1'b1; cpu = 1'b0;
        @(negedge clk); start = 1'b0;
        wait_end();
        chk(n_done == d0 + 1, "R8 request while busy ignored", n_done - d0, 1);
        chk(rel_o == 2'b11, "R8 CPU1 completed", int'(rel_o), 3);
        chk(busy_o == 1'b0, "R10 idle after done", int'(busy_o), 0);

        // Timeout boundary: acknowledge latency is DLY-1 wait cycles
        do_reset();
        lim = 16'(DLY - 2); e0 = n_err;
        pulse_start(1);
        wait_end();
        chk(n_err == e0 + 1, "R9 limit below latency times out", n_err - e0, 1);
        chk(rel_o == 2'b00 && pon_o == 4'b1100, "R9 no release after abort", int'({rel_o, pon_o}), 'h0C);
        do_reset();
        lim = 16'(DLY - 1); d0 = n_done;
        pulse_start(1);
        wait_end();
        chk(n_done == d0 + 1, "R9 limit at latency completes", n_done - d0, 1);
        chk(rel_o == 2'b10, "R7 CPU1 released alone", int'(rel_o), 2);

        // Memory-stage timeout on CPU0 (R6, R9)
        lim = 16'd3; kill_mok = 2'b01; e0 = n_err;
        pulse_start(0);
        wait_end();
        chk(n_err == e0 + 1 && mok_o[0] && mclamp_o[0] && !rel_o[0], "R6 memory clamp kept on abort",
            int'({mok_o[0], mclamp_o[0], rel_o[0]}), 'b110);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule